// File: doc/BRIEF.md
# Four-State Skip Counter

This block is a 3-bit synchronous counter that steps through four chosen codes in a fixed order that is not binary: 001, 010, 101, 111, and then back to 001. The next state comes from JK excitation equations, one pair for each state bit. All three bits are clocked on the same edge. It suits small sequencers that need a short repeating pattern of codes without a decoder after a binary count.

The four codes outside the cycle (000, 011, 100, 110) were treated as free choices when the equations were derived. The same equations still run on those codes, and they always lead back into the cycle within three enabled clocks, so the counter cannot lock up in a stray loop. A synchronous reset loads a start code, which is 001 by default. When the enable input is low, the state holds.

Top module: `skipSeqCounter`

## Requirements
- R1: When `rst` is high at a rising edge, `stateOut` becomes the parameter `ResetCode` (default 3'b001) one clock later, whatever the level of `countEn`.
- R2: With `countEn` high and `rst` low, each rising edge moves `stateOut` one step along the cycle 001 → 010 → 101 → 111 → 001.
- R3: With `countEn` low and `rst` low, `stateOut` keeps its value across the edge.
- R4: Once `stateOut` holds one of the four cycle codes, no sequence of enable levels makes it leave those codes unless `rst` is applied.
- R5: On an enabled edge, the unused codes move as follows: 000 → 011, 011 → 100, 100 → 111, 110 → 001.
- R6: Starting from any unused code, `stateOut` is inside the cycle after at most three enabled edges.
- R7: Reset with `countEn` low still loads `ResetCode`. An enabled step on the edge after reset starts from that code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| countEn | input | 1 | Step enable, active high |
| stateOut | output | 3 | Current counter code, bit 2 is the most significant bit |

## Verification
Every result of this block appears exactly one rising edge after the inputs that cause it: a reset load, a step or a hold all show on `stateOut` after that single register. The bench changes `rst` and `countEn` on the falling edge. It samples one nanosecond after the next rising edge, when it also advances its reference model by one step. It checks eight instances at once, each with a different `ResetCode`, so that every unused code is used as a start point. A counter for each instance tracks how many enabled edges are spent outside the cycle, which bounds the three-edge recovery window.

// File: rtl/skip_seq_pkg.sv
package skip_seq_pkg;

  localparam int StateBits = 3;

  typedef logic [StateBits-1:0] seqCode_t;

  // strobes passed from control to the datapath
  typedef struct packed {
    logic load;   // take the reset code
    logic step;   // apply the JK excitation
  } ctlStrobes_t;

  function automatic logic isMainCode(input seqCode_t c);
    return (c == 3'b001) || (c == 3'b010) || (c == 3'b101) || (c == 3'b111);
  endfunction

endpackage

// File: rtl/skip_seq_ctrl.sv
module skip_seq_ctrl
  import skip_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        countEn,
  output ctlStrobes_t strobes
);

  always_comb begin
    strobes.load = rst;
    strobes.step = countEn && !rst;
  end

  // R1, R7: reset wins over enable, so the strobes never both fire
  a_r1_strobe_excl: assert property (@(posedge clk)
    !(strobes.load && strobes.step));

endmodule

// File: rtl/skip_seq_datapath.sv
module skip_seq_datapath
  import skip_seq_pkg::*;
#(
  parameter seqCode_t ResetCode = 3'b001,
  parameter int       RecoverMax = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  ctlStrobes_t strobes,
  output seqCode_t    stateQ
);

  localparam int RecW = $clog2(RecoverMax + 2);

  seqCode_t jIn, kIn, stateD;

  // excitation: J0=1, K0=~Q2, J1=K1=1, J2=K2=Q1
  always_comb begin
    jIn[0] = 1'b1;
    kIn[0] = ~stateQ[2];
    jIn[1] = 1'b1;
    kIn[1] = 1'b1;
    jIn[2] = stateQ[1];
    kIn[2] = stateQ[1];
  end

  for (genvar b = 0; b < StateBits; b++) begin : g_jk
    always_comb begin
      if (strobes.load)
        stateD[b] = ResetCode[b];
      else if (strobes.step)
        stateD[b] = (jIn[b] & ~stateQ[b]) | (~kIn[b] & stateQ[b]);
      else
        stateD[b] = stateQ[b];
    end

    always_ff @(posedge clk) begin
      stateQ[b] <= stateD[b];
    end
  end

  // enabled edges spent outside the cycle, used by the recovery check
  logic [RecW-1:0] offRun;
  always_ff @(posedge clk) begin
    if (rst)
      offRun <= '0;
    else if (isMainCode(stateQ))
      offRun <= '0;
    else if (strobes.step && offRun != RecW'(RecoverMax + 1))
      offRun <= offRun + 1'b1;
  end

  a_r1_reset_load: assert property (@(posedge clk)
    rst |=> stateQ == ResetCode);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.step |=> $stable(stateQ));

  a_r4_cycle_closed: assert property (@(posedge clk) disable iff (rst)
    isMainCode(stateQ) |=> isMainCode(stateQ));

  a_r6_recovery_bound: assert property (@(posedge clk) disable iff (rst)
    offRun <= RecW'(RecoverMax));

endmodule

// File: rtl/skipSeqCounter.sv
module skipSeqCounter
  import skip_seq_pkg::*;
#(
  parameter logic [2:0] ResetCode = 3'b001
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       countEn,
  output logic [2:0] stateOut
);

  ctlStrobes_t strobes;
  seqCode_t    stateQ;

  skip_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .countEn (countEn),
    .strobes (strobes)
  );

  skip_seq_datapath #(
    .ResetCode (ResetCode),
    .RecoverMax(3)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .stateQ  (stateQ)
  );

  assign stateOut = stateQ;

endmodule

// File: tb/skipSeqCounter_tb.sv
`timescale 1ns/1ps
module skipSeqCounter_tb;

  localparam int Lanes = 8;

  logic       clk = 1'b0;
  logic       rstV [Lanes];
  logic       enV  [Lanes];
  logic [2:0] outV [Lanes];
  logic [2:0] expV [Lanes];
  int         offCnt [Lanes];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < Lanes; g++) begin : g_lane
    skipSeqCounter #(.ResetCode(3'(g))) u_dut (
      .clk     (clk),
      .rst     (rstV[g]),
      .countEn (enV[g]),
      .stateOut(outV[g])
    );
  end

  // reference from R2 and R5
  function automatic logic [2:0] refNext(input logic [2:0] s);
    case (s)
      3'b001: return 3'b010;
      3'b010: return 3'b101;
      3'b101: return 3'b111;
      3'b111: return 3'b001;
      3'b000: return 3'b011;
      3'b011: return 3'b100;
      3'b100: return 3'b111;
      default: return 3'b001;
    endcase
  endfunction

  function automatic bit inCyc(input logic [2:0] s);
    return s == 3'b001 || s == 3'b010 || s == 3'b101 || s == 3'b111;
  endfunction

  task automatic check(input string req, input int lane, input logic [2:0] act,
                       input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s lane %0d actual %b expected %b", req, lane, act, exp);
    end
  endtask

  // drive on negedge, advance model on posedge, compare 1 ns later
  task automatic cycle(input string req);
    bit wasIn [Lanes];
    @(posedge clk);
    for (int l = 0; l < Lanes; l++) begin
      wasIn[l] = inCyc(expV[l]);
      if (rstV[l]) begin
        expV[l] = 3'(l);
        offCnt[l] = 0;
      end else if (enV[l]) begin
        expV[l] = refNext(expV[l]);
        if (!wasIn[l]) offCnt[l]++;
      end
      if (inCyc(expV[l])) offCnt[l] = 0;
    end
    #1;
    for (int l = 0; l < Lanes; l++) begin
      check(req, l, outV[l], expV[l]);
      if (wasIn[l] && !rstV[l]) begin
        checks++;
        if (!inCyc(outV[l])) begin
          errors++;
          $display("FAIL R4 lane %0d actual %b expected a cycle code", l, outV[l]);
        end
      end
      checks++;
      if (offCnt[l] > 3) begin
        errors++;
        $display("FAIL R6 lane %0d actual %0d enabled edges off-cycle expected <= 3",
                 l, offCnt[l]);
      end
    end
    @(negedge clk);
  endtask

  task automatic setAll(input logic r, input logic e);
    for (int l = 0; l < Lanes; l++) begin
      rstV[l] = r;
      enV[l]  = e;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < Lanes; l++) begin
      expV[l] = 3'bx;
      offCnt[l] = 0;
    end
    setAll(1'b1, 1'b1);
    @(negedge clk);
    cycle("R1");                       // reset with enable high
    setAll(1'b1, 1'b0);
    cycle("R7");                       // reset with enable low
    setAll(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) cycle("R2_R5_R6");  // full loop and recovery
    setAll(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cycle("R3");
    setAll(1'b1, 1'b0);
    cycle("R1");
    setAll(1'b0, 1'b1);
    cycle("R7");                       // first step right after reset
    for (int i = 0; i < 3000; i++) begin
      for (int l = 0; l < Lanes; l++) begin
        rstV[l] = ($urandom % 32) == 0;
        enV[l]  = ($urandom % 4) != 0;
      end
      cycle("R2_R3_R5");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule